// File: doc/BRIEF.md
# Receive Buffer with Fill-Driven Flow Control

This block sits between the deserialiser of an asynchronous serial port and the CPU that drains it. Each character arrives on a write strobe together with three error bits (parity, framing, break). The CPU removes characters one at a time with a read strobe, and the error bits travel through the queue with their character. After reset the block holds a single character. With the queue mode enabled it buffers up to sixteen.

With automatic flow control enabled, the block drives the request-to-send handshake line itself. The line drops as soon as the fill level reaches the selected trigger level, and it rises again only once the queue has been drained empty. This lets the remote transmitter stop before the queue can overflow. A character that arrives with no room left is discarded and raises a sticky overrun flag. A data-ready output doubles as the receive DMA request, and a trigger flag reports that the fill level is at or above the threshold.

Top module: `rx_fifo_autorts`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears to `data_ready`=0, `overrun`=0, `trig_hit`=0, `rts`=1 and `rd_data`/`rd_pe`/`rd_fe`/`rd_brk`=0. `rts`=1 means the far end may send.
- R2: With `fifo_en`=1, up to 16 entries are held. They are returned in arrival order, and each entry keeps its 8-bit data together with its `pe`, `fe` and `brk` flags.
- R3: With `fifo_en`=0, which is the state after reset, only one entry is held. A second write that arrives before that entry is read counts as an overrun.
- R4: A write that arrives while the entry count equals the capacity is discarded and sets `overrun` on the next edge. The stored entries and their order are not changed. A read in the same cycle does not make room for that write.
- R5: `overrun` stays set until an `ovr_clr` pulse or reset. A flush does not change it. If a new overrun and `ovr_clr` occur in the same cycle, `overrun` stays set.
- R6: A `flush` pulse empties the queue at that edge. Any read or write in the same cycle is ignored.
- R7: `data_ready` is 1 exactly when at least one entry is stored. It reflects the count after each edge.
- R8: `trig_hit` is 1 when the count is at or above the threshold. In queue mode the threshold comes from `trig_sel`: 2'b00 gives 1, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 14. In single mode the threshold is 1.
- R9: With `autorts_en`=1 and `fifo_en`=1, `rts` goes to 0 at the edge where the count reaches the threshold. It returns to 1 only at the edge where the count becomes 0, and keeps its value at counts in between.
- R10: With `autorts_en`=0 or `fifo_en`=0, `rts` is 1 from the next edge.
- R11: Any change of `fifo_en` empties the queue at that edge, exactly as a flush does.
- R12: A read with `rd_stb`=1 and a non-empty queue places the head entry on `rd_data`/`rd_pe`/`rd_fe`/`rd_brk` at that edge, and those outputs then hold until the next such read. A read of an empty queue changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1 = 16-entry queue mode, 0 = single holding entry |
| autorts_en | input | 1 | Enables automatic control of `rts` |
| trig_sel | input | 2 | Trigger level code (1/4/8/14) |
| flush | input | 1 | Empties the queue |
| ovr_clr | input | 1 | Clears the overrun flag |
| wr_valid | input | 1 | Character strobe from the receiver |
| wr_data | input | 8 | Received character |
| wr_pe | input | 1 | Parity error of the character |
| wr_fe | input | 1 | Framing error of the character |
| wr_brk | input | 1 | Break condition of the character |
| rd_stb | input | 1 | CPU read strobe |
| rd_data | output | 8 | Last character read |
| rd_pe | output | 1 | Parity flag of the last character read |
| rd_fe | output | 1 | Framing flag of the last character read |
| rd_brk | output | 1 | Break flag of the last character read |
| data_ready | output | 1 | At least one entry stored; receive DMA request |
| overrun | output | 1 | Sticky overrun flag |
| trig_hit | output | 1 | Count at or above threshold |
| rts | output | 1 | Handshake output, 1 = far end may send |

## Verification
The hardest state to reach is a completely full queue that receives one more character while a read arrives in the same cycle. Reaching it needs sixteen back-to-back writes with no reads, and it must be shown afterwards that the dropped character left no trace in the order of the entries. A directed sequence fills the queue to the 14-entry trigger, checks that `rts` falls there, overfills it, and then drains every entry against the bench model. Random traffic with rare mode toggles and flushes then covers the hysteresis of `rts` between threshold and empty under every trigger code.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic brk;
    logic fe;
    logic pe;
  } err_t;

  localparam int ERR_W = 3;

  typedef enum logic [1:0] {
    TRIG_LVL_A = 2'b00,
    TRIG_LVL_B = 2'b01,
    TRIG_LVL_C = 2'b10,
    TRIG_LVL_D = 2'b11
  } trig_e;
endpackage

// File: rtl/rxq_ram.sv
module rxq_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 11,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_word,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_word
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_word <= '0;
    else if (rd_en) rd_word <= mem[rd_addr];
  end
endmodule

// File: rtl/rxq_ptrs.sv
module rxq_ptrs #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic          flush,
  input  logic          wr_valid,
  input  logic          rd_stb,
  input  logic          ovr_clr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic [CW-1:0] cnt_nxt,
  output logic          overrun
);
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt, cap;
  logic          fen_q, clear_all, no_room, ovr_set;

  assign clear_all = flush | (fifo_en ^ fen_q);
  assign cap       = fifo_en ? CW'(DEPTH) : CW'(1);
  assign no_room   = (cnt >= cap);
  assign wr_en     = wr_valid & ~no_room & ~clear_all;
  assign rd_en     = rd_stb & (cnt != '0) & ~clear_all;
  assign ovr_set   = wr_valid & no_room & ~clear_all;
  assign wr_addr   = wr_ptr;
  assign rd_addr   = rd_ptr;

  always_comb begin
    if (clear_all) cnt_nxt = '0;
    else           cnt_nxt = cnt + CW'(wr_en) - CW'(rd_en);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      cnt     <= '0;
      fen_q   <= 1'b0;
      overrun <= 1'b0;
    end else begin
      fen_q <= fifo_en;
      cnt   <= cnt_nxt;
      if (clear_all) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        if (wr_en) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
        if (rd_en) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
      if (ovr_set)      overrun <= 1'b1;
      else if (ovr_clr) overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/rxq_flow.sv
module rxq_flow
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL_A = 1,
  parameter int LVL_B = 4,
  parameter int LVL_C = 8,
  parameter int LVL_D = 14,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic          autorts_en,
  input  logic [1:0]    trig_sel,
  input  logic [CW-1:0] cnt_nxt,
  output logic          data_ready,
  output logic          trig_hit,
  output logic          rts
);
  logic [CW-1:0] lvl, thr;
  logic          at_thr, is_empty, auto_on;

  always_comb begin
    unique case (trig_e'(trig_sel))
      TRIG_LVL_A: lvl = CW'(LVL_A);
      TRIG_LVL_B: lvl = CW'(LVL_B);
      TRIG_LVL_C: lvl = CW'(LVL_C);
      default:    lvl = CW'(LVL_D);
    endcase
  end

  assign thr      = fifo_en ? lvl : CW'(1);
  assign at_thr   = (cnt_nxt >= thr);
  assign is_empty = (cnt_nxt == '0);
  assign auto_on  = autorts_en & fifo_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_ready <= 1'b0;
      trig_hit   <= 1'b0;
      rts        <= 1'b1;
    end else begin
      data_ready <= ~is_empty;
      trig_hit   <= at_thr;
      if (!auto_on)      rts <= 1'b1;
      else if (at_thr)   rts <= 1'b0;
      else if (is_empty) rts <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_fifo_autorts.sv
module rx_fifo_autorts
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int LVL_A  = 1,
  parameter int LVL_B  = 4,
  parameter int LVL_C  = 8,
  parameter int LVL_D  = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_en,
  input  logic              autorts_en,
  input  logic [1:0]        trig_sel,
  input  logic              flush,
  input  logic              ovr_clr,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_pe,
  input  logic              wr_fe,
  input  logic              wr_brk,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_pe,
  output logic              rd_fe,
  output logic              rd_brk,
  output logic              data_ready,
  output logic              overrun,
  output logic              trig_hit,
  output logic              rts
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = DATA_W + ERR_W;

  logic          wr_en, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [CW-1:0] cnt_nxt;
  logic [EW-1:0] wr_word, rd_word;
  err_t          wr_err, rd_err;

  assign wr_err  = '{brk: wr_brk, fe: wr_fe, pe: wr_pe};
  assign wr_word = {wr_err, wr_data};
  assign rd_err  = err_t'(rd_word[EW-1:DATA_W]);
  assign rd_data = rd_word[DATA_W-1:0];
  assign rd_pe   = rd_err.pe;
  assign rd_fe   = rd_err.fe;
  assign rd_brk  = rd_err.brk;

  rxq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .flush(flush),
    .wr_valid(wr_valid), .rd_stb(rd_stb), .ovr_clr(ovr_clr),
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_en(rd_en), .rd_addr(rd_addr),
    .cnt_nxt(cnt_nxt), .overrun(overrun)
  );

  rxq_ram #(.DEPTH(DEPTH), .WIDTH(EW)) u_ram (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_word(wr_word),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_word(rd_word)
  );

  rxq_flow #(
    .DEPTH(DEPTH), .LVL_A(LVL_A), .LVL_B(LVL_B), .LVL_C(LVL_C), .LVL_D(LVL_D)
  ) u_flow (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .autorts_en(autorts_en),
    .trig_sel(trig_sel), .cnt_nxt(cnt_nxt),
    .data_ready(data_ready), .trig_hit(trig_hit), .rts(rts)
  );
endmodule

// File: rtl/rx_fifo_autorts_chk.sv
module rx_fifo_autorts_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              fifo_en,
  input logic              autorts_en,
  input logic              flush,
  input logic              ovr_clr,
  input logic              rd_stb,
  input logic [DATA_W-1:0] rd_data,
  input logic              data_ready,
  input logic              overrun,
  input logic              trig_hit,
  input logic              rts
);
  // R1: reset state
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!data_ready && !overrun && !trig_hit && rts));

  // R6: a flush leaves nothing to read
  assert_flush_empties_R6: assert property (@(posedge clk) disable iff (rst)
    flush |=> !data_ready);

  // R5: overrun is sticky until a clear
  assert_ovr_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (overrun && !ovr_clr) |=> overrun);

  // R8: reaching a threshold of at least one implies stored data
  assert_trig_needs_data_R8: assert property (@(posedge clk) disable iff (rst)
    trig_hit |-> data_ready);

  // R10: handshake held asserted without automatic control
  assert_rts_manual_R10: assert property (@(posedge clk) disable iff (rst)
    (!autorts_en || !fifo_en) |=> rts);

  // R9: at or above threshold under automatic control the handshake is low
  assert_rts_low_at_trig_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(autorts_en && fifo_en) && trig_hit) |-> !rts);

  // R12: read data only changes after a read strobe
  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(rd_data));
endmodule

bind rx_fifo_autorts rx_fifo_autorts_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .fifo_en(fifo_en), .autorts_en(autorts_en),
  .flush(flush), .ovr_clr(ovr_clr), .rd_stb(rd_stb), .rd_data(rd_data),
  .data_ready(data_ready), .overrun(overrun), .trig_hit(trig_hit), .rts(rts)
);

// File: tb/rx_fifo_autorts_tb.sv
module rx_fifo_autorts_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fifo_en = 0, autorts_en = 0, flush = 0, ovr_clr = 0;
  logic [1:0] trig_sel = 0;
  logic       wr_valid = 0, wr_pe = 0, wr_fe = 0, wr_brk = 0, rd_stb = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic       rd_pe, rd_fe, rd_brk, data_ready, overrun, trig_hit, rts;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // bench model state
  logic [10:0] q[$];
  logic [10:0] m_rd = '0;
  bit m_ovr = 0, m_rts = 1, m_fen = 0, m_dr = 0, m_trig = 0;
  bit c_auto = 0, c_fe = 0;

  always #5 clk = ~clk;

  rx_fifo_autorts u_dut (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .autorts_en(autorts_en),
    .trig_sel(trig_sel), .flush(flush), .ovr_clr(ovr_clr),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_pe(wr_pe), .wr_fe(wr_fe),
    .wr_brk(wr_brk), .rd_stb(rd_stb), .rd_data(rd_data), .rd_pe(rd_pe),
    .rd_fe(rd_fe), .rd_brk(rd_brk), .data_ready(data_ready),
    .overrun(overrun), .trig_hit(trig_hit), .rts(rts)
  );

  function automatic int thr_of(bit fe, bit [1:0] ts);
    if (!fe) return 1;
    case (ts)
      2'b00: return 1;
      2'b01: return 4;
      2'b10: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [10:0] got;
    got = {rd_brk, rd_fe, rd_pe, rd_data};
    chk(got == m_rd, c_fe ? "R2" : "R3", "read entry", got, m_rd);
    chk(data_ready == m_dr, "R7", "data_ready", data_ready, m_dr);
    chk(overrun == m_ovr, "R4", "overrun", overrun, m_ovr);
    chk(trig_hit == m_trig, "R8", "trig_hit", trig_hit, m_trig);
    chk(rts == m_rts, (c_auto && c_fe) ? "R9" : "R10", "rts", rts, m_rts);
  endtask

  task automatic model(bit fe, bit ae, bit [1:0] ts, bit fl, bit wv,
                       logic [10:0] wd, bit rs, bit oc);
    bit clr, ovr_set;
    int cap, n, thr;
    clr = fl || (fe != m_fen);
    m_fen = fe;
    cap = fe ? 16 : 1;
    n = q.size();
    ovr_set = 0;
    if (clr) q.delete();
    else begin
      if (rs && n > 0) m_rd = q.pop_front();
      if (wv) begin
        if (n < cap) q.push_back(wd);
        else ovr_set = 1;
      end
    end
    if (ovr_set) m_ovr = 1;
    else if (oc) m_ovr = 0;
    n = q.size();
    thr = thr_of(fe, ts);
    m_dr = (n != 0);
    m_trig = (n >= thr);
    if (!(ae && fe)) m_rts = 1;
    else if (n >= thr) m_rts = 0;
    else if (n == 0) m_rts = 1;
    c_auto = ae;
    c_fe = fe;
  endtask

  // drive at posedge+2, advance one edge, compare at posedge+2
  task automatic step(bit fe, bit ae, bit [1:0] ts, bit fl, bit wv,
                      logic [10:0] wd, bit rs, bit oc);
    fifo_en = fe; autorts_en = ae; trig_sel = ts; flush = fl;
    wr_valid = wv; {wr_brk, wr_fe, wr_pe, wr_data} = wd; rd_stb = rs;
    ovr_clr = oc;
    model(fe, ae, ts, fl, wv, wd, rs, oc);
    @(posedge clk);
    #2;
    compare_all();
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++;
        n_tests++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    bit fe, ae, fl, wv, rs, oc;
    bit [1:0] ts;
    logic [10:0] wd;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    chk(data_ready == 0 && overrun == 0 && trig_hit == 0 && rts == 1 &&
        rd_data == 0, "R1", "reset outputs",
        {rd_data, data_ready, overrun, trig_hit, rts}, 12'h001);
    rst = 0;

    // R3: single holding entry in default mode
    step(0, 0, 0, 0, 1, 11'h5A5, 0, 0);
    chk(data_ready == 1, "R7", "dr after one write", data_ready, 1);
    step(0, 0, 0, 0, 1, 11'h0C3, 0, 0);
    chk(overrun == 1, "R3", "second write overruns", overrun, 1);
    step(0, 0, 0, 0, 0, 0, 1, 0);
    chk({rd_brk, rd_fe, rd_pe, rd_data} == 11'h5A5, "R3", "kept first entry",
        {rd_brk, rd_fe, rd_pe, rd_data}, 11'h5A5);
    // R5: clear
    step(0, 0, 0, 0, 0, 0, 0, 1);
    chk(overrun == 0, "R5", "ovr_clr clears", overrun, 0);

    // R11: mode change flushes
    step(0, 0, 0, 0, 1, 11'h011, 0, 0);
    step(1, 1, 2'b11, 0, 0, 0, 0, 0);
    chk(data_ready == 0, "R11", "mode switch empties", data_ready, 0);

    // R9 / R8: fill toward trigger 14
    for (int i = 0; i < 14; i++) begin
      step(1, 1, 2'b11, 0, 1, 11'(i * 37 + 3), 0, 0);
      if (i == 12) chk(rts == 1, "R9", "rts at 13", rts, 1);
    end
    chk(rts == 0 && trig_hit == 1, "R9", "rts low at 14", {rts, trig_hit}, 2'b01);
    step(1, 1, 2'b11, 0, 1, 11'h7F0, 0, 0);
    step(1, 1, 2'b11, 0, 1, 11'h7F1, 0, 0);
    // R4: full plus read plus write: dropped
    step(1, 1, 2'b11, 0, 1, 11'h3EE, 1, 0);
    chk(overrun == 1, "R4", "overrun at full", overrun, 1);
    step(1, 1, 2'b11, 0, 1, 11'h3EF, 0, 0);
    step(1, 1, 2'b11, 0, 1, 11'h3AB, 0, 0);
    chk(overrun == 1, "R4", "overrun again", overrun, 1);
    // R2: drain all in order, rts hysteresis
    for (int i = 0; i < 16; i++) begin
      step(1, 1, 2'b11, 0, 0, 0, 1, 0);
      if (i == 10) chk(rts == 0, "R9", "rts holds while draining", rts, 0);
    end
    chk(rts == 1 && data_ready == 0, "R9", "rts back at empty", {rts, data_ready}, 2'b10);

    // R5 / R6: flush keeps overrun
    step(1, 0, 2'b01, 0, 1, 11'h101, 0, 0);
    step(1, 0, 2'b01, 0, 1, 11'h102, 0, 0);
    step(1, 0, 2'b01, 1, 1, 11'h103, 1, 0);
    chk(data_ready == 0, "R6", "flush empties", data_ready, 0);
    chk(overrun == 1, "R5", "flush keeps overrun", overrun, 1);
    // R12: read of empty changes nothing
    step(1, 0, 2'b01, 0, 0, 0, 1, 0);
    chk(rd_data == m_rd[7:0], "R12", "empty read", rd_data, m_rd[7:0]);

    // constrained random traffic
    fe = 1; ae = 1; ts = 2'b01;
    for (int k = 0; k < 6000; k++) begin
      if ($urandom_range(0, 299) == 0) fe = ~fe;
      if ($urandom_range(0, 99) == 0) ae = ~ae;
      if ($urandom_range(0, 99) == 0) ts = 2'($urandom_range(0, 3));
      fl = ($urandom_range(0, 149) == 0);
      wv = ($urandom_range(0, 99) < 50);
      rs = ($urandom_range(0, 99) < 42);
      oc = ($urandom_range(0, 49) == 0);
      wd = 11'($urandom);
      step(fe, ae, ts, fl, wv, wd, rs, oc);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule